// File: doc/BRIEF.md
# Host-Side Serial Read Initiator

This block is the host end of a serial bridge for a display bus. It samples a CPU parallel interface (an active-low strobe, a read/write select, a strobe-source select, six control lines and a parallel/serial mode select). It turns each read request into a short control frame on an outgoing serial line. It then waits for a data frame on the incoming serial line, deserializes the 18-bit result, and drives it onto the CPU data bus until the CPU latches it with a rising strobe.

A second operating mode lets a serial-peripheral host drive the same pins. The top control line acts as the serial clock and the next one as the serial data. Each rising serial clock edge sends the control-type signals, together with the chip select, as one control frame. This mode starts no read and waits for no reply.

Both serial lines run at one bit per clock and idle high. A frame is a low start bit, a frame-type bit (0 = control, 1 = data), the payload least significant bit first, and a high stop bit.

Top module: `rd_link_initiator`

## Requirements
- R1: After reset `tx_ser` is 1, and `busy`, `dbus_oe`, `proto_err` and `timeout_err` are 0.
- R2: With `par_mode` high and `rd_wr` high, a falling `strobe_n` sampled at a clock edge sets `busy` after that edge. From the next cycle on, `tx_ser` sends 11 bits, one per cycle, in this order: start 0, type 0, `ctl[0]`..`ctl[5]`, `rd_wr`, `src_sel`, stop 1. After the stop bit the line returns high.
- R3: A falling `strobe_n` while `rd_wr` is low sends no frame and leaves `busy` low.
- R4: While `busy` is high, further strobe edges are ignored: no frame is sent and `busy` stays high.
- R5: While busy, an incoming frame on `rx_ser` with start 0, type 1, 18 data bits LSB first and stop 1 makes `dbus_out` carry the data with `dbus_oe` high and `busy` low, starting in the cycle after the stop bit is sampled.
- R6: An incoming frame whose type bit is 0, or whose stop bit is 0, is dropped: `busy` stays high and `dbus_oe` stays low.
- R7: Returned data stays on `dbus_out` with `dbus_oe` high until `strobe_n` rises; after that edge `dbus_oe` is low and the block is idle.
- R8: If `rd_wr` goes low while `busy`, the read aborts at the next edge. `busy` clears, `tx_ser` returns high even in the middle of a frame, and `proto_err` pulses high for exactly one cycle.
- R9: If no valid data frame arrives, `busy` stays high for exactly `TIMEOUT` cycles (default 1024), then clears, and `timeout_err` pulses for one cycle.
- R10: With `par_mode` low and `src_sel` low, a rising edge on `ctl[5]` sends a control frame with payload bits 0..5 = `ctl`, bit 6 = `rd_wr`, bit 7 = `cs_n`. `busy` stays low.
- R11: With `par_mode` low, a rising `ctl[5]` while `src_sel` is high sends nothing, and falling strobes start no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link and logic clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strobe_n | input | 1 | CPU strobe, falling edge starts a read, rising edge latches data |
| rd_wr | input | 1 | Read (1) / write (0) select |
| src_sel | input | 1 | Strobe-source select |
| par_mode | input | 1 | 1 = parallel bus mode, 0 = serial-peripheral mode |
| ctl | input | 6 | Control lines; in serial-peripheral mode bit 5 is serial clock, bit 4 serial data |
| cs_n | input | 1 | Serial-peripheral chip select, carried in serial-peripheral frames |
| dbus_out | output | 18 | Returned read data |
| dbus_oe | output | 1 | Data bus drive enable for returned data |
| tx_ser | output | 1 | Outgoing serial line, idles high |
| rx_ser | input | 1 | Incoming serial line, idles high |
| busy | output | 1 | Read in flight |
| proto_err | output | 1 | One-cycle pulse: read/write changed during a read |
| timeout_err | output | 1 | One-cycle pulse: no data frame returned in time |

## Verification
A wrong sequencer state shows up on `busy` or `dbus_oe` within one cycle of the edge that caused it. It shows as a read that never starts, a strobe that starts a second frame, or data released before the strobe rises. A slip in the transmit shift register or its bit count shows as a misplaced bit in the 11 cycles after capture. The bench compares each frame bit by bit. A receiver that loses its bit position or accepts a bad type or stop bit shows up as wrong `dbus_out` contents or an early fall of `busy` right after the stop bit. Timeout counter faults move the `busy` fall or the `timeout_err` pulse by whole cycles, and the bench samples these at the exact cycle.

// File: rtl/rli_pkg.sv
package rli_pkg;

    typedef enum logic [1:0] {
        CT_IDLE,
        CT_WAIT,
        CT_HOLD
    } ctl_state_e;

    typedef enum logic [1:0] {
        RX_HUNT,
        RX_TYPE,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    localparam logic FRAME_CTRL = 1'b0;
    localparam logic FRAME_DATA = 1'b1;

endpackage

// File: rtl/rli_tx.sv
module rli_tx
    import rli_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          abort_i,
    input  logic [PW-1:0] payload_i,
    output logic          ser_o,
    output logic          active_o
);

    localparam int FL = PW + 3;
    localparam int LW = $clog2(FL + 1);

    typedef struct packed {
        logic          active;
        logic [FL-1:0] sr;
        logic [LW-1:0] left;
    } tx_reg_t;

    tx_reg_t q, d;

    always_comb begin
        d = q;
        if (abort_i) begin
            d.active = 1'b0;
            d.left   = '0;
            d.sr     = '1;
        end else if (load_i && !q.active) begin
            d.active = 1'b1;
            d.sr     = {1'b1, payload_i, FRAME_CTRL, 1'b0};
            d.left   = LW'(FL);
        end else if (q.active) begin
            d.sr   = {1'b1, q.sr[FL-1:1]};
            d.left = q.left - LW'(1);
            if (q.left == LW'(1)) begin
                d.active = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{active: 1'b0, sr: '1, left: '0};
        end else begin
            q <= d;
        end
    end

    assign ser_o    = q.active ? q.sr[0] : 1'b1;
    assign active_o = q.active;

    // R2
    tx_load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !q.active);

    // R2
    tx_start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !abort_i) |=> (ser_o == 1'b0));

    // R8
    tx_abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> ser_o);

endmodule

// File: rtl/rli_rx.sv
module rli_rx
    import rli_pkg::*;
#(
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          rx_i,
    output logic          valid_o,
    output logic [DW-1:0] data_o
);

    localparam int IW = $clog2(DW);

    typedef struct packed {
        rx_state_e     st;
        logic [DW-1:0] sr;
        logic [IW-1:0] idx;
    } rx_reg_t;

    rx_reg_t q, d;
    logic    valid;

    always_comb begin
        d     = q;
        valid = 1'b0;
        if (!en_i) begin
            d.st = RX_HUNT;
        end else begin
            unique case (q.st)
                RX_HUNT: begin
                    if (!rx_i) begin
                        d.st = RX_TYPE;
                    end
                end
                RX_TYPE: begin
                    d.idx = '0;
                    d.st  = (rx_i == FRAME_DATA) ? RX_DATA : RX_HUNT;
                end
                RX_DATA: begin
                    d.sr = {rx_i, q.sr[DW-1:1]};
                    if (q.idx == IW'(DW - 1)) begin
                        d.st = RX_STOP;
                    end else begin
                        d.idx = q.idx + IW'(1);
                    end
                end
                RX_STOP: begin
                    d.st  = RX_HUNT;
                    valid = rx_i;
                end
                default: d.st = RX_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: RX_HUNT, sr: '0, idx: '0};
        end else begin
            q <= d;
        end
    end

    assign valid_o = valid;
    assign data_o  = q.sr;

    // R5
    rx_valid_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> en_i);

    // R6
    rx_stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> rx_i);

endmodule

// File: rtl/rli_ctrl.sv
module rli_ctrl
    import rli_pkg::*;
#(
    parameter int CW      = 6,
    parameter int DW      = 18,
    parameter int TIMEOUT = 1024
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            strobe_n_i,
    input  logic            rd_wr_i,
    input  logic            src_sel_i,
    input  logic            par_mode_i,
    input  logic [CW-1:0]   ctl_i,
    input  logic            cs_n_i,
    input  logic            tx_active_i,
    input  logic            rx_valid_i,
    input  logic [DW-1:0]   rx_data_i,
    output logic            tx_load_o,
    output logic            tx_abort_o,
    output logic [CW+1:0]   tx_payload_o,
    output logic            rx_en_o,
    output logic            busy_o,
    output logic [DW-1:0]   dbus_o,
    output logic            dbus_oe_o,
    output logic            proto_err_o,
    output logic            timeout_err_o
);

    localparam int SCLK_BIT = CW - 1;
    localparam int TW       = $clog2(TIMEOUT);

    typedef struct packed {
        ctl_state_e    st;
        logic          stb_prev;
        logic          sclk_prev;
        logic [TW-1:0] cnt;
        logic [DW-1:0] dout;
        logic          perr;
        logic          terr;
    } ctl_reg_t;

    ctl_reg_t q, d;
    logic     stb_fall, stb_rise, sclk_rise;
    logic     load, abort;
    logic [CW+1:0] payload;

    assign stb_fall  = q.stb_prev & ~strobe_n_i;
    assign stb_rise  = ~q.stb_prev & strobe_n_i;
    assign sclk_rise = ~q.sclk_prev & ctl_i[SCLK_BIT];

    always_comb begin
        d           = q;
        d.stb_prev  = strobe_n_i;
        d.sclk_prev = ctl_i[SCLK_BIT];
        d.perr      = 1'b0;
        d.terr      = 1'b0;
        load        = 1'b0;
        abort       = 1'b0;
        payload     = {src_sel_i, rd_wr_i, ctl_i};
        unique case (q.st)
            CT_IDLE: begin
                if (par_mode_i) begin
                    if (stb_fall && rd_wr_i && !tx_active_i) begin
                        load  = 1'b1;
                        d.st  = CT_WAIT;
                        d.cnt = '0;
                    end
                end else begin
                    payload = {cs_n_i, rd_wr_i, ctl_i};
                    if (sclk_rise && !src_sel_i && !tx_active_i) begin
                        load = 1'b1;
                    end
                end
            end
            CT_WAIT: begin
                if (!rd_wr_i) begin
                    abort  = 1'b1;
                    d.perr = 1'b1;
                    d.st   = CT_IDLE;
                end else if (rx_valid_i) begin
                    d.dout = rx_data_i;
                    d.st   = CT_HOLD;
                end else if (q.cnt == TW'(TIMEOUT - 1)) begin
                    abort  = 1'b1;
                    d.terr = 1'b1;
                    d.st   = CT_IDLE;
                end else begin
                    d.cnt = q.cnt + TW'(1);
                end
            end
            CT_HOLD: begin
                if (stb_rise) begin
                    d.st = CT_IDLE;
                end
            end
            default: d.st = CT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: CT_IDLE, stb_prev: 1'b1, sclk_prev: 1'b1, cnt: '0,
                   dout: '0, perr: 1'b0, terr: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign tx_load_o     = load;
    assign tx_abort_o    = abort;
    assign tx_payload_o  = payload;
    assign rx_en_o       = (q.st == CT_WAIT);
    assign busy_o        = (q.st == CT_WAIT);
    assign dbus_oe_o     = (q.st == CT_HOLD);
    assign dbus_o        = q.dout;
    assign proto_err_o   = q.perr;
    assign timeout_err_o = q.terr;

    // R4
    no_reload_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !tx_load_o);

    // R7
    busy_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && dbus_oe_o));

    // R5
    oe_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dbus_oe_o) |-> $fell(busy_o));

    // R8
    proto_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err_o |-> $fell(busy_o));

    // R9
    timeout_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err_o |=> !timeout_err_o);

    // R10
    spi_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_load_o && !par_mode_i) |=> !busy_o);

endmodule

// File: rtl/rd_link_initiator.sv
module rd_link_initiator #(
    parameter int CW      = 6,
    parameter int DW      = 18,
    parameter int TIMEOUT = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe_n,
    input  logic          rd_wr,
    input  logic          src_sel,
    input  logic          par_mode,
    input  logic [CW-1:0] ctl,
    input  logic          cs_n,
    output logic [DW-1:0] dbus_out,
    output logic          dbus_oe,
    output logic          tx_ser,
    input  logic          rx_ser,
    output logic          busy,
    output logic          proto_err,
    output logic          timeout_err
);

    localparam int PW = CW + 2;

    logic          tx_load, tx_abort, tx_active;
    logic [PW-1:0] tx_payload;
    logic          rx_en, rx_valid;
    logic [DW-1:0] rx_data;

    rli_ctrl #(.CW(CW), .DW(DW), .TIMEOUT(TIMEOUT)) i_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .strobe_n_i   (strobe_n),
        .rd_wr_i      (rd_wr),
        .src_sel_i    (src_sel),
        .par_mode_i   (par_mode),
        .ctl_i        (ctl),
        .cs_n_i       (cs_n),
        .tx_active_i  (tx_active),
        .rx_valid_i   (rx_valid),
        .rx_data_i    (rx_data),
        .tx_load_o    (tx_load),
        .tx_abort_o   (tx_abort),
        .tx_payload_o (tx_payload),
        .rx_en_o      (rx_en),
        .busy_o       (busy),
        .dbus_o       (dbus_out),
        .dbus_oe_o    (dbus_oe),
        .proto_err_o  (proto_err),
        .timeout_err_o(timeout_err)
    );

    rli_tx #(.PW(PW)) i_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tx_load),
        .abort_i   (tx_abort),
        .payload_i (tx_payload),
        .ser_o     (tx_ser),
        .active_o  (tx_active)
    );

    rli_rx #(.DW(DW)) i_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (rx_en),
        .rx_i    (rx_ser),
        .valid_o (rx_valid),
        .data_o  (rx_data)
    );

endmodule

// File: tb/test_rd_link_initiator.sv
module test_rd_link_initiator;

    localparam int TO = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strobe_n = 1'b1;
    logic        rd_wr = 1'b0;
    logic        src_sel = 1'b0;
    logic        par_mode = 1'b1;
    logic [5:0]  ctl = 6'h00;
    logic        cs_n = 1'b1;
    logic [17:0] dbus_out;
    logic        dbus_oe;
    logic        tx_ser;
    logic        rx_ser = 1'b1;
    logic        busy;
    logic        proto_err;
    logic        timeout_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    rd_link_initiator #(.TIMEOUT(TO)) i_rd_link_initiator (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_n   (strobe_n),
        .rd_wr      (rd_wr),
        .src_sel    (src_sel),
        .par_mode   (par_mode),
        .ctl        (ctl),
        .cs_n       (cs_n),
        .dbus_out   (dbus_out),
        .dbus_oe    (dbus_oe),
        .tx_ser     (tx_ser),
        .rx_ser     (rx_ser),
        .busy       (busy),
        .proto_err  (proto_err),
        .timeout_err(timeout_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [10:0] ctrl_frame(input logic [7:0] p);
        return {1'b1, p, 1'b0, 1'b0};
    endfunction

    // samples 11 bits, the first at the current negedge
    task automatic grab_frame(output logic [10:0] f);
        f[0] = tx_ser;
        for (int i = 1; i < 11; i++) begin
            @(negedge clk);
            f[i] = tx_ser;
        end
    endtask

    task automatic line_quiet(input string req, input int cycles, input logic exp_busy);
        int bad = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (tx_ser !== 1'b1 || busy !== exp_busy) bad++;
        end
        chk(req, bad, 0);
    endtask

    task automatic send_frame(input logic typ, input logic [17:0] data, input logic stp);
        @(negedge clk) rx_ser = 1'b0;
        @(negedge clk) rx_ser = typ;
        for (int i = 0; i < 18; i++) begin
            @(negedge clk) rx_ser = data[i];
        end
        @(negedge clk) rx_ser = stp;
        @(negedge clk) rx_ser = 1'b1;
    endtask

    task automatic start_read(input logic [5:0] c, input logic ss);
        @(negedge clk);
        par_mode = 1'b1;
        rd_wr    = 1'b1;
        src_sel  = ss;
        ctl      = c;
        strobe_n = 1'b0;
        @(negedge clk);
    endtask

    task automatic end_read();
        @(negedge clk);
        strobe_n = 1'b1;
        rd_wr    = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 tx_ser", tx_ser, 1);
        chk("R1 busy", busy, 0);
        chk("R1 dbus_oe", dbus_oe, 0);
        chk("R1 errors", {proto_err, timeout_err}, 0);
    endtask

    task automatic t_read(input logic [5:0] c, input logic ss, input logic [17:0] data);
        logic [10:0] f;
        start_read(c, ss);
        chk("R2 busy set", busy, 1);
        grab_frame(f);
        chk("R2 control frame", f, ctrl_frame({ss, 1'b1, c}));
        // R4: a second strobe with other control values while busy
        @(negedge clk) strobe_n = 1'b1;
        @(negedge clk) begin strobe_n = 1'b0; ctl = ~c; end
        line_quiet("R4 strobe ignored while busy", 12, 1'b1);
        send_frame(1'b1, data, 1'b1);
        chk("R5 busy cleared", busy, 0);
        chk("R5 dbus_oe", dbus_oe, 1);
        chk("R5 data", dbus_out, data);
        repeat (3) @(negedge clk);
        chk("R7 data held", {dbus_oe, dbus_out}, {1'b1, data});
        strobe_n = 1'b1;
        @(negedge clk);
        chk("R7 released", dbus_oe, 0);
        chk("R7 idle", busy, 0);
        rd_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_write_ignored();
        @(negedge clk);
        rd_wr = 1'b0; ctl = 6'h15; strobe_n = 1'b0;
        line_quiet("R3 write strobe sends nothing", 12, 1'b0);
        strobe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_bad_frames();
        start_read(6'h0A, 1'b0);
        repeat (12) @(negedge clk);
        send_frame(1'b0, 18'h3FFFF, 1'b1);
        chk("R6 type0 dropped busy", busy, 1);
        chk("R6 type0 dropped oe", dbus_oe, 0);
        send_frame(1'b1, 18'h12345, 1'b0);
        chk("R6 bad stop busy", busy, 1);
        chk("R6 bad stop oe", dbus_oe, 0);
        send_frame(1'b1, 18'h2A5C3, 1'b1);
        chk("R6 good after bad", {dbus_oe, dbus_out}, {1'b1, 18'h2A5C3});
        end_read();
    endtask

    task automatic t_proto();
        start_read(6'h33, 1'b1);
        repeat (3) @(negedge clk);
        rd_wr = 1'b0;
        @(negedge clk);
        chk("R8 proto_err", proto_err, 1);
        chk("R8 busy cleared", busy, 0);
        chk("R8 line idle", tx_ser, 1);
        @(negedge clk);
        chk("R8 one-cycle pulse", proto_err, 0);
        end_read();
    endtask

    task automatic t_timeout();
        start_read(6'h01, 1'b0);
        chk("R9 busy start", busy, 1);
        repeat (TO - 1) @(negedge clk);
        chk("R9 busy at last cycle", {busy, timeout_err}, 2'b10);
        @(negedge clk);
        chk("R9 timeout", {busy, timeout_err}, 2'b01);
        @(negedge clk);
        chk("R9 one-cycle pulse", timeout_err, 0);
        end_read();
    endtask

    task automatic t_spi(input logic sdat, input logic cs, input logic rw);
        logic [10:0] f;
        logic [5:0]  c;
        @(negedge clk);
        par_mode = 1'b0; src_sel = 1'b0; cs_n = cs; rd_wr = rw;
        ctl = {1'b0, sdat, 4'h9};
        repeat (2) @(negedge clk);
        c = {1'b1, sdat, 4'h9};
        ctl = c;
        @(negedge clk);
        chk("R10 no busy", busy, 0);
        grab_frame(f);
        chk("R10 spi frame", f, ctrl_frame({cs, rw, c}));
        @(negedge clk) ctl = {1'b0, sdat, 4'h9};
        @(negedge clk);
    endtask

    task automatic t_spi_ignored();
        @(negedge clk);
        par_mode = 1'b0; src_sel = 1'b1; ctl = 6'h00;
        repeat (2) @(negedge clk);
        ctl = 6'h20;
        line_quiet("R11 src_sel high ignored", 12, 1'b0);
        src_sel = 1'b0; rd_wr = 1'b1; strobe_n = 1'b0;
        line_quiet("R11 strobe ignored in serial mode", 12, 1'b0);
        strobe_n = 1'b1; rd_wr = 1'b0; par_mode = 1'b1; ctl = 6'h00;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read(6'h2D, 1'b0, 18'h2B3C1);
        t_read(6'h12, 1'b1, 18'h3FFFF);
        t_read(6'h00, 1'b0, 18'h00001);
        t_write_ignored();
        t_bad_frames();
        t_proto();
        t_timeout();
        t_spi(1'b1, 1'b0, 1'b0);
        t_spi(1'b0, 1'b1, 1'b1);
        t_spi_ignored();
        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule